// File: doc/BRIEF.md
# Lockable Unified TLB Controller

This block is a small translation lookaside buffer shared by instruction and data fetches. It holds 4 KB page translations in two stores: a two-way set-associative main store of 16 sets, and a fully associative store of eight pinned slots. A lookup presents a virtual address. One cycle later the block returns a response strobe, a hit flag, the physical page number and a flag that tells whether the hit came from a pinned slot.

An external page walker supplies translations through the fill port. A placement register, written through its own strobe, sends each fill either to the main store or to one chosen pinned slot. In the main store the set comes from the low page-number bits and a per-set round-robin bit picks the way.

A write-only maintenance port takes a command selector pair: a 4-bit group code and a 3-bit operation code. It also takes an address operand that is used by the single-page operation. The flush-all operation empties only the main store, so pinned slots survive a context-wide flush. The single-page operation removes the page from both stores.

Top module: `utlb_ctrl`

## Requirements
- R1: After reset no translation is valid in either store, every lookup misses, and the placement register selects the main store.
- R2: A lookup request in cycle N gives rsp_valid high in cycle N+1 with the hit flag, the page number and the pinned flag. rsp_valid is low after a cycle with no request. On a miss rsp_ppn is zero and rsp_lock is low.
- R3: With the placement select bit at 0, a fill goes to the main store set given by VA[15:12]. The way comes from that set's round-robin bit, which starts at way 0 and toggles on every fill to the set. A third fill of a distinct page into a set therefore evicts the first.
- R4: With the placement select bit at 1, a fill writes the pinned slot named by the 3-bit slot field of the placement register and replaces whatever that slot held.
- R5: Flush-all (group 5, 6 or 7 with operation 0) invalidates every main-store entry and leaves every pinned slot valid.
- R6: Single-page invalidate (group 5, 6 or 7 with operation 1) removes every entry whose page number equals mnt_va[31:12], in both stores, and leaves other pages valid.
- R7: Groups 5 (instruction side), 6 (data side) and 7 (unified) all act on the same shared store.
- R8: Any other group/operation pair leaves both stores unchanged.
- R9: When a page is present in both stores, the lookup returns the pinned slot's page number with rsp_lock high.
- R10: When a maintenance command and a lookup arrive in the same cycle, the lookup sees the state after the command.
- R11: Address bits [11:0] have no effect on a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| rsp_valid | output | 1 | Response strobe, one cycle after lk_req |
| rsp_hit | output | 1 | Translation found |
| rsp_lock | output | 1 | Hit came from a pinned slot |
| rsp_ppn | output | PA_W-12 | Physical page number, zero on miss |
| fill_en | input | 1 | Write a translation from the page walker |
| fill_va | input | VA_W | Virtual address of the fill |
| fill_ppn | input | PA_W-12 | Physical page number of the fill |
| vic_we | input | 1 | Write the placement register |
| vic_to_lock | input | 1 | Placement select: 1 pinned store, 0 main store |
| vic_slot | input | clog2(LOCK_N) | Pinned slot index for fills |
| mnt_en | input | 1 | Maintenance command strobe |
| mnt_crm | input | 4 | Command group code |
| mnt_op2 | input | 3 | Command operation code |
| mnt_va | input | VA_W | Address operand of the single-page command |

## Verification
The functions that can fall in the same cycle are a lookup and a maintenance invalidate. The bench provokes this by raising lk_req and mnt_en on one clock edge for the same page. It does this for a flush-all that hits a main-store page, a flush-all that hits a pinned page, and a single-page invalidate. It judges the response in the following cycle: the main-store hit must be gone, the pinned hit must remain, and the single-page target must miss.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  localparam int PAGE_BITS = 12;

  localparam logic [3:0] GRP_INST = 4'd5;
  localparam logic [3:0] GRP_DATA = 4'd6;
  localparam logic [3:0] GRP_UNIF = 4'd7;

  localparam logic [2:0] OPC_ALL = 3'd0;
  localparam logic [2:0] OPC_ONE = 3'd1;
endpackage

// File: rtl/utlb_cmd_dec.sv
module utlb_cmd_dec
  import utlb_pkg::*;
(
  input  logic       mnt_en,
  input  logic [3:0] mnt_crm,
  input  logic [2:0] mnt_op2,
  output logic       inv_all,
  output logic       inv_one
);
  logic grp_ok;

  // all three groups address the same shared store
  always_comb begin
    grp_ok  = (mnt_crm == GRP_INST) || (mnt_crm == GRP_DATA) || (mnt_crm == GRP_UNIF);
    inv_all = mnt_en && grp_ok && (mnt_op2 == OPC_ALL);
    inv_one = mnt_en && grp_ok && (mnt_op2 == OPC_ONE);
  end
endmodule

// File: rtl/utlb_assoc.sv
module utlb_assoc #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int SETS  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inv_all,
  input  logic             inv_one,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn
);
  localparam int WAYS  = 2;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;

  logic [WAYS-1:0]  vld_q [SETS];
  logic [SETS-1:0]  rr_q;

  logic [IDX_W-1:0] look_idx, fill_idx, inv_idx;
  logic [TAG_W-1:0] look_tag, fill_tag, inv_tag;
  logic             fill_way;

  logic [TAG_W-1:0] rd_tag_look [WAYS];
  logic [PPN_W-1:0] rd_ppn_look [WAYS];
  logic [TAG_W-1:0] rd_tag_inv  [WAYS];
  logic [WAYS-1:0]  look_match;
  logic [WAYS-1:0]  inv_match;

  assign look_idx = look_vpn[IDX_W-1:0];
  assign look_tag = look_vpn[VPN_W-1:IDX_W];
  assign fill_idx = fill_vpn[IDX_W-1:0];
  assign fill_tag = fill_vpn[VPN_W-1:IDX_W];
  assign inv_idx  = inv_vpn[IDX_W-1:0];
  assign inv_tag  = inv_vpn[VPN_W-1:IDX_W];
  assign fill_way = rr_q[fill_idx];

  // per-way tag and page arrays: single write port, no reset
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    logic [PPN_W-1:0] ppn_mem [SETS];

    always_ff @(posedge clk) begin
      if (fill_en && (fill_way == 1'(w))) begin
        tag_mem[fill_idx] <= fill_tag;
        ppn_mem[fill_idx] <= fill_ppn;
      end
    end

    assign rd_tag_look[w] = tag_mem[look_idx];
    assign rd_ppn_look[w] = ppn_mem[look_idx];
    assign rd_tag_inv[w]  = tag_mem[inv_idx];
    assign look_match[w]  = vld_q[look_idx][w] && (rd_tag_look[w] == look_tag);
    assign inv_match[w]   = rd_tag_inv[w] == inv_tag;
  end

  // valid bits and round-robin pointers; invalidate is applied before the fill
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      rr_q <= '0;
    end else begin
      if (inv_all) begin
        for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else if (inv_one) begin
        for (int w = 0; w < WAYS; w++) begin
          if (inv_match[w]) vld_q[inv_idx][w] <= 1'b0;
        end
      end
      if (fill_en) begin
        vld_q[fill_idx][fill_way] <= 1'b1;
        rr_q[fill_idx]            <= ~fill_way;
      end
    end
  end

  always_comb begin
    hit     = |look_match;
    hit_ppn = look_match[0] ? rd_ppn_look[0] : rd_ppn_look[1];
  end

  logic [SETS*WAYS-1:0] vld_flat;
  always_comb begin
    for (int s = 0; s < SETS; s++) vld_flat[s*WAYS +: WAYS] = vld_q[s];
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    inv_all && !fill_en |=> vld_flat == '0);  // R5

  AST_RR_ONE_FLIP: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> $countones(rr_q ^ $past(rr_q)) == 1);  // R3

  AST_RR_QUIET: assert property (@(posedge clk) disable iff (rst)
    !fill_en |=> $stable(rr_q));  // R3
endmodule

// File: rtl/utlb_lock.sv
module utlb_lock #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int SLOTS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inv_one,
  input  logic [VPN_W-1:0]         inv_vpn,
  input  logic                     fill_en,
  input  logic [$clog2(SLOTS)-1:0] fill_slot,
  input  logic [VPN_W-1:0]         fill_vpn,
  input  logic [PPN_W-1:0]         fill_ppn,
  input  logic [VPN_W-1:0]         look_vpn,
  output logic                     hit,
  output logic [PPN_W-1:0]         hit_ppn
);
  logic [SLOTS-1:0] vld_q;
  logic [VPN_W-1:0] vpn_q [SLOTS];
  logic [PPN_W-1:0] ppn_q [SLOTS];

  always_ff @(posedge clk) begin
    if (fill_en) begin
      vpn_q[fill_slot] <= fill_vpn;
      ppn_q[fill_slot] <= fill_ppn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      if (inv_one) begin
        for (int i = 0; i < SLOTS; i++) begin
          if (vpn_q[i] == inv_vpn) vld_q[i] <= 1'b0;
        end
      end
      if (fill_en) vld_q[fill_slot] <= 1'b1;
    end
  end

  // lowest slot wins if a page was pinned twice
  always_comb begin
    hit     = 1'b0;
    hit_ppn = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (vld_q[i] && (vpn_q[i] == look_vpn)) begin
        hit     = 1'b1;
        hit_ppn = ppn_q[i];
      end
    end
  end

  AST_SLOT_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> vld_q[$past(fill_slot)] && (vpn_q[$past(fill_slot)] == $past(fill_vpn)));  // R4

  AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !inv_one |=> ((vld_q & $past(vld_q)) == $past(vld_q)));  // R5
endmodule

// File: rtl/utlb_ctrl.sv
module utlb_ctrl
  import utlb_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int SETS   = 16,
  parameter int LOCK_N = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      lk_req,
  input  logic [VA_W-1:0]           lk_va,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic                      rsp_lock,
  output logic [PA_W-13:0]          rsp_ppn,
  input  logic                      fill_en,
  input  logic [VA_W-1:0]           fill_va,
  input  logic [PA_W-13:0]          fill_ppn,
  input  logic                      vic_we,
  input  logic                      vic_to_lock,
  input  logic [$clog2(LOCK_N)-1:0] vic_slot,
  input  logic                      mnt_en,
  input  logic [3:0]                mnt_crm,
  input  logic [2:0]                mnt_op2,
  input  logic [VA_W-1:0]           mnt_va
);
  localparam int VPN_W  = VA_W - PAGE_BITS;
  localparam int PPN_W  = PA_W - PAGE_BITS;
  localparam int SLOT_W = $clog2(LOCK_N);

  logic [VPN_W-1:0] look_vpn, fill_vpn, inv_vpn;
  logic             unused_offsets;

  assign look_vpn       = lk_va[VA_W-1:PAGE_BITS];
  assign fill_vpn       = fill_va[VA_W-1:PAGE_BITS];
  assign inv_vpn        = mnt_va[VA_W-1:PAGE_BITS];
  assign unused_offsets = ^{lk_va[PAGE_BITS-1:0], fill_va[PAGE_BITS-1:0], mnt_va[PAGE_BITS-1:0]};

  // placement register
  logic              vic_lock_q;
  logic [SLOT_W-1:0] vic_slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vic_lock_q <= 1'b0;
      vic_slot_q <= '0;
    end else if (vic_we) begin
      vic_lock_q <= vic_to_lock;
      vic_slot_q <= vic_slot;
    end
  end

  logic inv_all, inv_one;

  utlb_cmd_dec u_dec (
    .mnt_en  (mnt_en),
    .mnt_crm (mnt_crm),
    .mnt_op2 (mnt_op2),
    .inv_all (inv_all),
    .inv_one (inv_one)
  );

  logic             a_hit, l_hit;
  logic [PPN_W-1:0] a_ppn, l_ppn;

  utlb_assoc #(.VPN_W(VPN_W), .PPN_W(PPN_W), .SETS(SETS)) u_assoc (
    .clk      (clk),
    .rst      (rst),
    .inv_all  (inv_all),
    .inv_one  (inv_one),
    .inv_vpn  (inv_vpn),
    .fill_en  (fill_en && !vic_lock_q),
    .fill_vpn (fill_vpn),
    .fill_ppn (fill_ppn),
    .look_vpn (look_vpn),
    .hit      (a_hit),
    .hit_ppn  (a_ppn)
  );

  utlb_lock #(.VPN_W(VPN_W), .PPN_W(PPN_W), .SLOTS(LOCK_N)) u_lock (
    .clk       (clk),
    .rst       (rst),
    .inv_one   (inv_one),
    .inv_vpn   (inv_vpn),
    .fill_en   (fill_en && vic_lock_q),
    .fill_slot (vic_slot_q),
    .fill_vpn  (fill_vpn),
    .fill_ppn  (fill_ppn),
    .look_vpn  (look_vpn),
    .hit       (l_hit),
    .hit_ppn   (l_ppn)
  );

  // same-cycle invalidates mask the lookup so the command lands first
  logic kill_one, a_eff, l_eff;

  always_comb begin
    kill_one = inv_one && (inv_vpn == look_vpn);
    a_eff    = a_hit && !inv_all && !kill_one;
    l_eff    = l_hit && !kill_one;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_lock  <= 1'b0;
      rsp_ppn   <= '0;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= lk_req && (a_eff || l_eff);
      rsp_lock  <= lk_req && l_eff;
      if (lk_req && l_eff)      rsp_ppn <= l_ppn;
      else if (lk_req && a_eff) rsp_ppn <= a_ppn;
      else                      rsp_ppn <= '0;
    end
  end

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> rsp_valid);  // R2

  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !rsp_valid && !rsp_hit);  // R2

  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_hit |-> (rsp_ppn == '0) && !rsp_lock);  // R2

  AST_PIN_FIRST: assert property (@(posedge clk) disable iff (rst)
    lk_req && l_hit && !kill_one |=> rsp_hit && rsp_lock);  // R9

  AST_FLUSH_BEFORE_LOOK: assert property (@(posedge clk) disable iff (rst)
    lk_req && inv_all && !l_hit |=> !rsp_hit);  // R10
endmodule

// File: tb/utlb_ctrl_tb.sv
module utlb_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_req = 1'b0;
  logic [31:0] lk_va = '0;
  logic        rsp_valid, rsp_hit, rsp_lock;
  logic [19:0] rsp_ppn;
  logic        fill_en = 1'b0;
  logic [31:0] fill_va = '0;
  logic [19:0] fill_ppn = '0;
  logic        vic_we = 1'b0;
  logic        vic_to_lock = 1'b0;
  logic [2:0]  vic_slot = '0;
  logic        mnt_en = 1'b0;
  logic [3:0]  mnt_crm = '0;
  logic [2:0]  mnt_op2 = '0;
  logic [31:0] mnt_va = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  utlb_ctrl u_dut (
    .clk(clk), .rst(rst),
    .lk_req(lk_req), .lk_va(lk_va),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_lock(rsp_lock), .rsp_ppn(rsp_ppn),
    .fill_en(fill_en), .fill_va(fill_va), .fill_ppn(fill_ppn),
    .vic_we(vic_we), .vic_to_lock(vic_to_lock), .vic_slot(vic_slot),
    .mnt_en(mnt_en), .mnt_crm(mnt_crm), .mnt_op2(mnt_op2), .mnt_va(mnt_va)
  );

  task automatic judge(input string req, input logic e_hit, input logic [19:0] e_ppn, input logic e_lock);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_hit !== e_hit || rsp_ppn !== e_ppn || rsp_lock !== e_lock) begin
      errors++;
      $display("FAIL %s: valid=%0b hit=%0b ppn=%h lock=%0b expected valid=1 hit=%0b ppn=%h lock=%0b",
               req, rsp_valid, rsp_hit, rsp_ppn, rsp_lock, e_hit, e_ppn, e_lock);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic e_hit, input logic [19:0] e_ppn,
                      input logic e_lock, input string req);
    @(negedge clk);
    lk_req = 1'b1; lk_va = va;
    @(negedge clk);
    lk_req = 1'b0;
    judge(req, e_hit, e_ppn, e_lock);
  endtask

  task automatic fill(input logic [31:0] va, input logic [19:0] ppn);
    @(negedge clk);
    fill_en = 1'b1; fill_va = va; fill_ppn = ppn;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic place(input logic to_lock, input logic [2:0] slot);
    @(negedge clk);
    vic_we = 1'b1; vic_to_lock = to_lock; vic_slot = slot;
    @(negedge clk);
    vic_we = 1'b0;
  endtask

  task automatic cmd(input logic [3:0] crm, input logic [2:0] op2, input logic [31:0] va);
    @(negedge clk);
    mnt_en = 1'b1; mnt_crm = crm; mnt_op2 = op2; mnt_va = va;
    @(negedge clk);
    mnt_en = 1'b0;
  endtask

  task automatic look_with_cmd(input logic [31:0] va, input logic [3:0] crm, input logic [2:0] op2,
                               input logic [31:0] inv_va, input logic e_hit, input logic [19:0] e_ppn,
                               input logic e_lock, input string req);
    @(negedge clk);
    lk_req = 1'b1; lk_va = va;
    mnt_en = 1'b1; mnt_crm = crm; mnt_op2 = op2; mnt_va = inv_va;
    @(negedge clk);
    lk_req = 1'b0; mnt_en = 1'b0;
    judge(req, e_hit, e_ppn, e_lock);
  endtask

  task automatic t_reset;
    checks++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid=%0b hit=%0b expected 0 0", rsp_valid, rsp_hit);
    end
    look(32'h0000_1000, 1'b0, 20'h0, 1'b0, "R1 empty after reset");
    // default placement is the main store: a flush-all must remove it
    fill(32'h0000_1000, 20'h00011);
    look(32'h0000_1000, 1'b1, 20'h00011, 1'b0, "R1 default placement main");
    cmd(4'd7, 3'd0, 32'h0);
    look(32'h0000_1000, 1'b0, 20'h0, 1'b0, "R1 default fill is flushable");
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2: idle valid=%0b expected 0", rsp_valid);
    end
  endtask

  task automatic t_assoc;
    fill(32'h0001_3000, 20'h00111);
    fill(32'h0002_3000, 20'h00222);
    look(32'h0001_3000, 1'b1, 20'h00111, 1'b0, "R3 way0");
    look(32'h0002_3000, 1'b1, 20'h00222, 1'b0, "R3 way1");
    look(32'h0001_3ABC, 1'b1, 20'h00111, 1'b0, "R11 offset ignored");
    look(32'h0002_3FFF, 1'b1, 20'h00222, 1'b0, "R11 offset ignored");
    fill(32'h0003_3000, 20'h00333);
    look(32'h0001_3000, 1'b0, 20'h0, 1'b0, "R3 round robin evicts first");
    look(32'h0002_3000, 1'b1, 20'h00222, 1'b0, "R3 second kept");
    look(32'h0003_3000, 1'b1, 20'h00333, 1'b0, "R3 third placed");
    look(32'h0001_4000, 1'b0, 20'h0, 1'b0, "R2 miss other set");
  endtask

  task automatic t_lock;
    place(1'b1, 3'd2);
    fill(32'h0040_0000, 20'h00444);
    look(32'h0040_0000, 1'b1, 20'h00444, 1'b1, "R4 pinned slot");
    fill(32'h0050_0000, 20'h00555);
    look(32'h0040_0000, 1'b0, 20'h0, 1'b0, "R4 slot overwritten");
    look(32'h0050_0000, 1'b1, 20'h00555, 1'b1, "R4 new occupant");
    place(1'b1, 3'd7);
    fill(32'h0060_0000, 20'h00666);
    look(32'h0060_0000, 1'b1, 20'h00666, 1'b1, "R4 last slot");
    place(1'b0, 3'd0);
  endtask

  task automatic t_flush;
    cmd(4'd7, 3'd0, 32'h0);
    look(32'h0003_3000, 1'b0, 20'h0, 1'b0, "R5 main entry flushed");
    look(32'h0050_0000, 1'b1, 20'h00555, 1'b1, "R5 pinned survives");
    look(32'h0060_0000, 1'b1, 20'h00666, 1'b1, "R5 pinned survives");
    fill(32'h0003_3000, 20'h00333);
    cmd(4'd5, 3'd0, 32'h0);
    look(32'h0003_3000, 1'b0, 20'h0, 1'b0, "R7 instruction-side flush");
    look(32'h0060_0000, 1'b1, 20'h00666, 1'b1, "R7 instruction-side keeps pinned");
    fill(32'h0003_3000, 20'h00333);
    cmd(4'd6, 3'd0, 32'h0);
    look(32'h0003_3000, 1'b0, 20'h0, 1'b0, "R7 data-side flush");
    look(32'h0050_0000, 1'b1, 20'h00555, 1'b1, "R7 data-side keeps pinned");
  endtask

  task automatic t_single;
    fill(32'h0007_5000, 20'h00777);
    fill(32'h0008_5000, 20'h00888);
    cmd(4'd6, 3'd1, 32'h0007_5123);
    look(32'h0007_5000, 1'b0, 20'h0, 1'b0, "R6 main page removed");
    look(32'h0008_5000, 1'b1, 20'h00888, 1'b0, "R6 neighbour kept");
    cmd(4'd5, 3'd1, 32'h0050_0000);
    look(32'h0050_0000, 1'b0, 20'h0, 1'b0, "R6 pinned page removed");
    look(32'h0060_0000, 1'b1, 20'h00666, 1'b1, "R6 other pinned kept");
    cmd(4'd7, 3'd1, 32'h0008_5000);
    look(32'h0008_5000, 1'b0, 20'h0, 1'b0, "R7 unified single removes");
  endtask

  task automatic t_noop;
    fill(32'h0008_5000, 20'h00888);
    cmd(4'd7, 3'd2, 32'h0008_5000);
    cmd(4'd8, 3'd0, 32'h0008_5000);
    cmd(4'd4, 3'd1, 32'h0060_0000);
    cmd(4'd6, 3'd4, 32'h0060_0000);
    look(32'h0008_5000, 1'b1, 20'h00888, 1'b0, "R8 main untouched");
    look(32'h0060_0000, 1'b1, 20'h00666, 1'b1, "R8 pinned untouched");
  endtask

  task automatic t_prio;
    place(1'b1, 3'd0);
    fill(32'h0009_2000, 20'h00AAA);
    place(1'b0, 3'd0);
    fill(32'h0009_2000, 20'h00BBB);
    look(32'h0009_2000, 1'b1, 20'h00AAA, 1'b1, "R9 pinned wins");
    cmd(4'd7, 3'd1, 32'h0009_2000);
    look(32'h0009_2000, 1'b0, 20'h0, 1'b0, "R6 both copies removed");
  endtask

  task automatic t_same_cycle;
    fill(32'h000A_6000, 20'h000CC);
    look_with_cmd(32'h000A_6000, 4'd7, 3'd0, 32'h0, 1'b0, 20'h0, 1'b0, "R10 flush before lookup");
    fill(32'h000A_6000, 20'h000CC);
    look_with_cmd(32'h0060_0000, 4'd7, 3'd0, 32'h0, 1'b1, 20'h00666, 1'b1, "R10 pinned hit with flush");
    look(32'h000A_6000, 1'b0, 20'h0, 1'b0, "R10 flush applied");
    fill(32'h000A_6000, 20'h000CC);
    look_with_cmd(32'h000A_6000, 4'd6, 3'd1, 32'h000A_6000, 1'b0, 20'h0, 1'b0, "R10 single before lookup");
    look_with_cmd(32'h0060_0000, 4'd5, 3'd1, 32'h0060_0000, 1'b0, 20'h0, 1'b0, "R10 pinned single before lookup");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_assoc();
    t_lock();
    t_flush();
    t_single();
    t_noop();
    t_prio();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule